// File: doc/BRIEF.md
# Byte-Serial Video Port Receiver

This block sits behind an external video input port and turns a byte-serial YCbCr 4:2:2 stream into tagged pixel bytes and timing. Every byte arrives with a qualifier. Only qualified bytes are looked at. The whole block runs in the port clock domain.

Line and frame timing comes from one of two sources, chosen by a static configuration word. The first source is a pair of discrete reference pins, one horizontal and one vertical. The second is timing codes embedded in the data. An embedded code is the preamble FF, 00, 00 followed by a flag byte. Only the field, vertical and horizontal flags of that byte are used; its protection bits are not checked.

The outputs are the pixel bytes, each tagged with its component phase. They come with an active-video level, one-cycle horizontal and vertical pulses, and a field level. The field can come from the horizontal level seen at the active vertical edge, or straight from a frame-sync level on the vertical pin.

Top module: `vid_port_rx`

## Requirements
- R1: A byte is processed only in a cycle where `dq_i` is high. In cycles where `dq_i` is low, nothing happens: `pix_vld_o`, `hs_o` and `vs_o` go low in the next cycle, and `act_o`, `fld_o` and the phase counter keep their values.
- R2: Each processed pixel byte appears on `pix_o` with `pix_vld_o` high in the clock cycle after it was sampled.
- R3: When `cfg_i[0]` is 1, timing is embedded. In this mode, byte FF is always withheld. A 00 that follows FF, or follows FF 00, is also withheld, and so is the flag byte after FF 00 00. Any other byte is output, including a lone 00 and the byte that breaks a partial preamble.
- R4: In the flag byte, bit 6 is the field, bit 5 is vertical blanking and bit 4 is H. H=0 marks start of active video and H=1 marks end of active video. Bit 7 and bits 3 to 0 have no effect.
- R5: `pix_ph_o` tags output bytes 0=Cb, 1=Y, 2=Cr, 3=Y, repeating. The counter restarts at 0 on the first byte after a start code in embedded mode, or on the first byte with active horizontal reference in discrete mode.
- R6: In embedded mode, `act_o` rises together with the withheld start code when its V=0, and stays low when V=1. It falls with the next FF.
- R7: In embedded mode, `hs_o` pulses for one cycle with each end code. `vs_o` pulses when the V flag goes from 0 to 1. `fld_o` follows the F flag of each code.
- R8: When `cfg_i[0]` is 0, timing is discrete. `act_o` equals `href_i` XOR `cfg_i[2]`. `hs_o` pulses on the first byte where that level is 1 after a byte where it was 0.
- R9: With `cfg_i[3]`=0, the active vertical edge is a 0-to-1 change of `vref_i` XOR `cfg_i[1]`. On that edge, `vs_o` pulses and `fld_o` takes the active horizontal level of the same byte. At all other times `fld_o` holds.
- R10: With `cfg_i[3]`=1, `fld_o` equals `vref_i` XOR `cfg_i[1]` on each byte. `vs_o` pulses whenever that level changes.
- R11: Synchronous reset clears every output and all internal timing state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 4 | Bit 0 embedded timing, bit 1 invert vertical, bit 2 invert horizontal, bit 3 frame-sync field mode |
| dq_i | input | 1 | Byte qualifier |
| din_i | input | DW | Incoming byte |
| href_i | input | 1 | Horizontal reference pin |
| vref_i | input | 1 | Vertical reference or frame-sync pin |
| pix_o | output | DW | Output pixel byte |
| pix_vld_o | output | 1 | Pixel byte valid |
| pix_ph_o | output | 2 | Component phase tag |
| act_o | output | 1 | Active video level |
| hs_o | output | 1 | Horizontal sync pulse |
| vs_o | output | 1 | Vertical sync pulse |
| fld_o | output | 1 | Field ID |

## Verification
In discrete mode, a line start and a vertical edge can fall on the same qualified byte. The bench provokes this by raising `href_i` and `vref_i` together. It then expects `hs_o` and `vs_o` in the same cycle, the field capturing the new high horizontal level, and phase 0. In embedded mode, a start code with V rising restarts the phase and pulses `vs_o` together. The bench judges this from the next pixel's phase tag and the pulse cycle.

// File: rtl/vid_port_rx_pkg.sv
package vid_port_rx_pkg;
  localparam int CFG_W     = 4;
  localparam int CFG_EMB   = 0;
  localparam int CFG_VINV  = 1;
  localparam int CFG_HINV  = 2;
  localparam int CFG_FSYNC = 3;

  localparam logic [1:0] PH_CB = 2'd0;

  // per-byte decision bundle produced by either timing decoder
  typedef struct packed {
    logic hold;  // byte is not pixel data
    logic sol;   // restart component phase
    logic act;   // active level after this byte
    logic hs;    // horizontal pulse
    logic vs;    // vertical pulse
    logic fld;   // field after this byte
  } tim_t;
endpackage

// File: rtl/vp_code_det.sv
module vp_code_det
  import vid_port_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  output tim_t          ev
);
  localparam int F_BIT = DW - 2;
  localparam int V_BIT = DW - 3;
  localparam int H_BIT = DW - 4;

  logic [1:0] m_q, m_nxt;
  logic       act_q, fld_q, v_q;
  logic       is_hi, is_lo, is_xy;

  always_comb begin
    is_hi = (din == {DW{1'b1}});
    is_lo = (din == {DW{1'b0}});
    is_xy = (m_q == 2'd3);
    ev.hold = is_xy | is_hi | (is_lo & (m_q != 2'd0));
    ev.sol  = is_xy & ~din[H_BIT];
    ev.hs   = is_xy & din[H_BIT];
    ev.vs   = is_xy & din[V_BIT] & ~v_q;
    if (is_xy)      ev.act = ~din[H_BIT] & ~din[V_BIT];
    else if (is_hi) ev.act = 1'b0;
    else            ev.act = act_q;
    ev.fld = is_xy ? din[F_BIT] : fld_q;
    if (is_xy)                         m_nxt = 2'd0;
    else if (is_hi)                    m_nxt = 2'd1;
    else if (is_lo && m_q != 2'd0)     m_nxt = m_q + 2'd1;
    else                               m_nxt = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q   <= 2'd0;
      act_q <= 1'b0;
      fld_q <= 1'b0;
      v_q   <= 1'b0;
    end else if (en) begin
      m_q   <= m_nxt;
      act_q <= ev.act;
      fld_q <= ev.fld;
      if (is_xy) v_q <= din[V_BIT];
    end
  end

  assert_code_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (en && m_q == 2'd3) |=> (m_q == 2'd0));

  assert_act_after_sav_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(act_q) && !$past(rst)) |-> ($past(en) && $past(m_q) == 2'd3));
endmodule

// File: rtl/vp_ref_sync.sv
module vp_ref_sync
  import vid_port_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic href,
  input  logic vref,
  input  logic hinv,
  input  logic vinv,
  input  logic fsync,
  output tim_t ev
);
  logic h_a, v_a, h_p, v_p, fld_q, v_edge;

  always_comb begin
    h_a    = href ^ hinv;
    v_a    = vref ^ vinv;
    v_edge = fsync ? (v_a != v_p) : (v_a & ~v_p);
    ev.hold = 1'b0;
    ev.sol  = h_a & ~h_p;
    ev.hs   = h_a & ~h_p;
    ev.act  = h_a;
    ev.vs   = v_edge;
    if (fsync)       ev.fld = v_a;
    else if (v_edge) ev.fld = h_a;
    else             ev.fld = fld_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_p   <= 1'b0;
      v_p   <= 1'b0;
      fld_q <= 1'b0;
    end else if (en) begin
      h_p   <= h_a;
      v_p   <= v_a;
      fld_q <= ev.fld;
    end
  end

  assert_field_at_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fsync) && fld_q != $past(fld_q))
      |-> ($past(en) && $past(v_a) && !$past(v_p)));
endmodule

// File: rtl/vp_out_stage.sv
module vp_out_stage
  import vid_port_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  input  tim_t          ev,
  output logic [DW-1:0] pix,
  output logic          pix_vld,
  output logic [1:0]    pix_ph,
  output logic          act,
  output logic          hs,
  output logic          vs,
  output logic          fld
);
  logic [1:0] cnt_q, base;

  always_comb base = ev.sol ? PH_CB : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix     <= '0;
      pix_vld <= 1'b0;
      pix_ph  <= PH_CB;
      act     <= 1'b0;
      hs      <= 1'b0;
      vs      <= 1'b0;
      fld     <= 1'b0;
      cnt_q   <= PH_CB;
    end else begin
      pix_vld <= en & ~ev.hold;
      hs      <= en & ev.hs;
      vs      <= en & ev.vs;
      if (en) begin
        act <= ev.act;
        fld <= ev.fld;
        if (!ev.hold) begin
          pix    <= din;
          pix_ph <= base;
          cnt_q  <= base + 2'd1;
        end else begin
          cnt_q  <= base;
        end
      end
    end
  end

  assert_valid_needs_dq_R1: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> $past(en));

  assert_hs_single_R7: assert property (@(posedge clk) disable iff (rst)
    hs |=> !hs);
endmodule

// File: rtl/vid_port_rx.sv
module vid_port_rx
  import vid_port_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             dq_i,
  input  logic [DW-1:0]    din_i,
  input  logic             href_i,
  input  logic             vref_i,
  output logic [DW-1:0]    pix_o,
  output logic             pix_vld_o,
  output logic [1:0]       pix_ph_o,
  output logic             act_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             fld_o
);
  tim_t code_ev, ref_ev, sel_ev;

  vp_code_det #(.DW(DW)) u_code (
    .clk (clk), .rst (rst), .en (dq_i), .din (din_i), .ev (code_ev)
  );

  vp_ref_sync u_ref (
    .clk   (clk),
    .rst   (rst),
    .en    (dq_i),
    .href  (href_i),
    .vref  (vref_i),
    .hinv  (cfg_i[CFG_HINV]),
    .vinv  (cfg_i[CFG_VINV]),
    .fsync (cfg_i[CFG_FSYNC]),
    .ev    (ref_ev)
  );

  always_comb sel_ev = cfg_i[CFG_EMB] ? code_ev : ref_ev;

  vp_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .en      (dq_i),
    .din     (din_i),
    .ev      (sel_ev),
    .pix     (pix_o),
    .pix_vld (pix_vld_o),
    .pix_ph  (pix_ph_o),
    .act     (act_o),
    .hs      (hs_o),
    .vs      (vs_o),
    .fld     (fld_o)
  );
endmodule

// File: tb/vid_port_rx_bench.sv
module vid_port_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg = 4'h1;
  logic       dq = 1'b0;
  logic [7:0] din = 8'h00;
  logic       href = 1'b0, vref = 1'b0;
  logic [7:0] pix;
  logic       vld, act, hs, vs, fld;
  logic [1:0] ph;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vid_port_rx u_vid_port_rx (
    .clk(clk), .rst(rst), .cfg_i(cfg), .dq_i(dq), .din_i(din),
    .href_i(href), .vref_i(vref), .pix_o(pix), .pix_vld_o(vld),
    .pix_ph_o(ph), .act_o(act), .hs_o(hs), .vs_o(vs), .fld_o(fld)
  );

  typedef struct packed {
    logic       r;
    logic [3:0] c;
    logic       q;
    logic [7:0] d;
    logic       h, v;
    logic       ev;
    logic [7:0] ed;
    logic [1:0] ep;
    logic       ea, ehs, evs, ef;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 58;
  // rst cfg dq din href vref | vld data ph act hs vs fld | requirement
  localparam vec_t TBL [NV] = '{
    // embedded timing: R11 R2 R1 R3 R4 R5 R6 R7
    '{1'b1,4'h1,1'b1,8'hAA,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11},
    '{1'b0,4'h1,1'b1,8'h10,1'b0,1'b0, 1'b1,8'h10,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd2},
    '{1'b0,4'h1,1'b0,8'h55,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd1},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd1},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h80,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd6},
    '{1'b0,4'h1,1'b1,8'h22,1'b0,1'b0, 1'b1,8'h22,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd5},
    '{1'b0,4'h1,1'b1,8'h33,1'b0,1'b0, 1'b1,8'h33,2'd1,1'b1,1'b0,1'b0,1'b0, 4'd5},
    '{1'b0,4'h1,1'b0,8'h77,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd1},
    '{1'b0,4'h1,1'b1,8'h44,1'b0,1'b0, 1'b1,8'h44,2'd2,1'b1,1'b0,1'b0,1'b0, 4'd5},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b1,8'h00,2'd3,1'b1,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h66,1'b0,1'b0, 1'b1,8'h66,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd5},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd6},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h9D,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b1,1'b0,1'b0, 4'd7},
    '{1'b0,4'h1,1'b1,8'h10,1'b0,1'b0, 1'b1,8'h10,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd5},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h5A,1'b0,1'b0, 1'b1,8'h5A,2'd2,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3},
    '{1'b0,4'h1,1'b1,8'hE0,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b1,1'b1, 4'd7},
    '{1'b0,4'h1,1'b1,8'h80,1'b0,1'b0, 1'b1,8'h80,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd6},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,4'h1,1'b1,8'hC0,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1,1'b0,1'b0,1'b1, 4'd6},
    '{1'b0,4'h1,1'b1,8'h11,1'b0,1'b0, 1'b1,8'h11,2'd0,1'b1,1'b0,1'b0,1'b1, 4'd5},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd6},
    '{1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd3},
    '{1'b0,4'h1,1'b1,8'h57,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b1,1'b0,1'b1, 4'd4},
    '{1'b0,4'h1,1'b1,8'h40,1'b0,1'b0, 1'b1,8'h40,2'd1,1'b0,1'b0,1'b0,1'b1, 4'd4},
    // discrete timing: R8 R9 R10 R11
    '{1'b1,4'h0,1'b1,8'hAA,1'b1,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11},
    '{1'b0,4'h0,1'b1,8'h01,1'b0,1'b0, 1'b1,8'h01,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd8},
    '{1'b0,4'h0,1'b1,8'h02,1'b1,1'b0, 1'b1,8'h02,2'd0,1'b1,1'b1,1'b0,1'b0, 4'd8},
    '{1'b0,4'h0,1'b1,8'h03,1'b1,1'b0, 1'b1,8'h03,2'd1,1'b1,1'b0,1'b0,1'b0, 4'd8},
    '{1'b0,4'h0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd1},
    '{1'b0,4'h0,1'b1,8'h04,1'b1,1'b0, 1'b1,8'h04,2'd2,1'b1,1'b0,1'b0,1'b0, 4'd8},
    '{1'b0,4'h0,1'b1,8'h05,1'b1,1'b1, 1'b1,8'h05,2'd3,1'b1,1'b0,1'b1,1'b1, 4'd9},
    '{1'b0,4'h0,1'b1,8'h06,1'b0,1'b1, 1'b1,8'h06,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd8},
    '{1'b0,4'h0,1'b1,8'h07,1'b0,1'b0, 1'b1,8'h07,2'd1,1'b0,1'b0,1'b0,1'b1, 4'd9},
    '{1'b0,4'h0,1'b1,8'h08,1'b0,1'b1, 1'b1,8'h08,2'd2,1'b0,1'b0,1'b1,1'b0, 4'd9},
    '{1'b1,4'h6,1'b1,8'hAA,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11},
    '{1'b0,4'h6,1'b1,8'h09,1'b1,1'b1, 1'b1,8'h09,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd8},
    '{1'b0,4'h6,1'b1,8'h0A,1'b0,1'b1, 1'b1,8'h0A,2'd0,1'b1,1'b1,1'b0,1'b0, 4'd8},
    '{1'b0,4'h6,1'b1,8'h0B,1'b0,1'b0, 1'b1,8'h0B,2'd1,1'b1,1'b0,1'b1,1'b1, 4'd9},
    '{1'b1,4'h8,1'b1,8'hAA,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11},
    '{1'b0,4'h8,1'b1,8'h0C,1'b0,1'b1, 1'b1,8'h0C,2'd0,1'b0,1'b0,1'b1,1'b1, 4'd10},
    '{1'b0,4'h8,1'b1,8'h0D,1'b0,1'b1, 1'b1,8'h0D,2'd1,1'b0,1'b0,1'b0,1'b1, 4'd10},
    '{1'b0,4'h8,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd1},
    '{1'b0,4'h8,1'b1,8'h0E,1'b0,1'b0, 1'b1,8'h0E,2'd2,1'b0,1'b0,1'b1,1'b0, 4'd10},
    '{1'b0,4'hA,1'b1,8'h0F,1'b0,1'b0, 1'b1,8'h0F,2'd3,1'b0,1'b0,1'b1,1'b1, 4'd10}
  };

  // drive at the falling edge, let one rising edge pass, sample 2 ns later
  task automatic run_vec(input vec_t v, input int idx);
    logic ok;
    @(negedge clk);
    rst = v.r; cfg = v.c; dq = v.q; din = v.d; href = v.h; vref = v.v;
    @(posedge clk);
    #2;
    ok = (vld == v.ev) && (act == v.ea) && (hs == v.ehs) && (vs == v.evs) &&
         (fld == v.ef) && (!v.ev || (pix == v.ed && ph == v.ep));
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d step %0d: got vld=%b pix=%h ph=%0d act=%b hs=%b vs=%b fld=%b exp vld=%b pix=%h ph=%0d act=%b hs=%b vs=%b fld=%b",
               v.req, idx, vld, pix, ph, act, hs, vs, fld,
               v.ev, v.ed, v.ep, v.ea, v.ehs, v.evs, v.ef);
    end
    dq = 1'b0;
    rst = 1'b0;
  endtask

  function automatic vec_t mk(input logic r, input logic [3:0] c, input logic q,
                              input logic [7:0] d, input logic h, input logic v,
                              input logic ev, input logic [7:0] ed, input logic [1:0] ep,
                              input logic ea, input logic ehs, input logic evs,
                              input logic ef, input logic [3:0] req);
    vec_t t;
    t = '{r, c, q, d, h, v, ev, ed, ep, ea, ehs, evs, ef, req};
    return t;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R8 R9 coincidence: line start and vertical edge on one byte
    run_vec(mk(1'b1,4'h0,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11), 100);
    run_vec(mk(1'b0,4'h0,1'b1,8'hC1,1'b1,1'b1, 1'b1,8'hC1,2'd0,1'b1,1'b1,1'b1,1'b1, 4'd9), 101);
    run_vec(mk(1'b0,4'h0,1'b1,8'hC2,1'b1,1'b1, 1'b1,8'hC2,2'd1,1'b1,1'b0,1'b0,1'b1, 4'd8), 102);

    // R5 long active line in embedded mode, then end code (R7)
    run_vec(mk(1'b1,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd11), 110);
    run_vec(mk(1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3), 111);
    run_vec(mk(1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3), 112);
    run_vec(mk(1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3), 113);
    run_vec(mk(1'b0,4'h1,1'b1,8'h0F,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1,1'b0,1'b0,1'b0, 4'd4), 114);
    for (int k = 0; k < 10; k++)
      run_vec(mk(1'b0,4'h1,1'b1,8'(8'h20 + k),1'b0,1'b0,
                 1'b1,8'(8'h20 + k),2'(k),1'b1,1'b0,1'b0,1'b0, 4'd5), 120 + k);
    run_vec(mk(1'b0,4'h1,1'b1,8'hFF,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd6), 140);
    run_vec(mk(1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3), 141);
    run_vec(mk(1'b0,4'h1,1'b1,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd3), 142);
    run_vec(mk(1'b0,4'h1,1'b1,8'h1F,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0,1'b1,1'b0,1'b0, 4'd7), 143);
    run_vec(mk(1'b0,4'h1,1'b1,8'h33,1'b0,1'b0, 1'b1,8'h33,2'd2,1'b0,1'b0,1'b0,1'b0, 4'd2), 144);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule